// File: doc/BRIEF.md
# Iterative Radix Conversion Engine

The engine turns an unsigned fixed-point number into a sequence of digits in a chosen radix between 2 and 16. The number has a 16-bit whole part and a 16-bit fractional part, with the binary point between them. A single `start` pulse latches the operands. The engine then streams the digits of the whole part, lowest weight first. Each of these digits comes from a restoring division by the radix that produces one quotient bit per clock. After the whole-part digits it streams the fractional digits, highest weight first. Each of those comes from a one-cycle multiplication of the remaining fraction by the radix.

Fractions such as 0.7 never end in binary. The number of fractional digits is therefore capped by a limit that is latched at start. The fractional digits also stop as soon as the remaining fraction is exactly zero.

Digits leave on a valid/ready stream. A digit is transferred on a clock edge where `dig_valid` and `dig_ready` are both high. While `dig_valid` is high and `dig_ready` is low, the digit and its flags are held unchanged, and the engine does no further work. `dig_valid` never depends on `dig_ready`. The control pins `start` and `busy` are plain levels.

Top module: `radix_digit_stream`

## Requirements
- R1: Whole-part digits are emitted with `dig_is_frac`=0, least significant first. Each digit is the remainder of the running value divided by the radix, and the quotient becomes the next running value. Whole-part emission ends with the digit whose quotient is zero (for example, 53 in radix 2 gives 1,0,1,0,1,1).
- R2: A whole part of zero emits exactly one digit, 0, with `dig_is_frac`=0, before any fractional digit.
- R3: Fractional digits are emitted with `dig_is_frac`=1, most significant first. Each digit is the integer part of the running fraction times the radix, and the fractional part of that product carries forward (for example, .625 in radix 2 gives 1,0,1).
- R4: No more than `frac_limit` fractional digits are emitted. A limit of 0 suppresses them entirely.
- R5: Fractional emission stops after the digit that leaves a remaining fraction of zero. A zero fractional input produces no fractional digits.
- R6: Every emitted digit is below the effective radix.
- R7: `dig_last` is high on exactly the final digit of a conversion. `busy` is low in the cycle after that digit transfers.
- R8: A `start` pulse while `busy` is high is ignored; the running conversion and its latched operands are unaffected.
- R9: While `dig_valid` is high and `dig_ready` is low, `dig_valid`, `dig_value`, `dig_is_frac` and `dig_last` stay stable.
- R10: A `radix` value below 2 is treated as 2, and a value above 16 is treated as 16.
- R11: After reset, `busy` and `dig_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a conversion when idle |
| radix | input | 5 | Target radix, clamped to 2..16 |
| frac_limit | input | 5 | Maximum number of fractional digits |
| value_int | input | 16 | Whole part of the operand |
| value_frac | input | 16 | Fractional part of the operand (weight 2^-1 at bit 15) |
| busy | output | 1 | Conversion in progress |
| dig_valid | output | 1 | A digit is offered |
| dig_ready | input | 1 | Sink accepts the offered digit |
| dig_value | output | 4 | Digit value |
| dig_is_frac | output | 1 | 1 for a fractional digit, 0 for a whole-part digit |
| dig_last | output | 1 | Final digit of the conversion |

## Verification
On every cycle, the assertions check the following:
- every offered remainder and fractional digit stays below the latched radix;
- the latched radix lies in 2..16;
- the fractional digit count stays within the limit;
- a stalled digit holds its value and flags;
- `busy` falls after the last transfer;
- a `start` pulse during a conversion does not end it.

The digit values themselves, their order, the early stop on a zero remainder, the single zero digit and the clamping of an out-of-range radix can only be shown by the bench. The bench compares whole sequences against an arithmetic model, using both steady and random back-pressure.

// File: rtl/rdx_pkg.sv
package rdx_pkg;
  localparam int INT_W   = 16;
  localparam int FRAC_W  = 16;
  localparam int RADIX_W = 5;
  localparam int LIM_W   = 5;
  localparam int DIGIT_W = RADIX_W - 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIV,
    ST_INT_OUT,
    ST_MUL,
    ST_FRAC_OUT
  } rdx_state_e;
endpackage

// File: rtl/rdx_div_unit.sv
module rdx_div_unit #(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] dividend,
  input  logic [DIV_W-1:0]  divisor,
  output logic              done,
  output logic [DATA_W-1:0] quotient,
  output logic [DIV_W-1:0]  remainder
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W-1:0] quo_q;
  logic [DIV_W-1:0]  rem_q, div_q, shifted, diff;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q, ge;

  assign shifted = {rem_q[DIV_W-2:0], quo_q[DATA_W-1]};
  assign ge      = (shifted >= div_q);
  assign diff    = shifted - div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q  <= '0;
      rem_q  <= '0;
      div_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        quo_q <= dividend;
        rem_q <= '0;
        div_q <= divisor;
        cnt_q <= CNT_W'(DATA_W);
      end else if (cnt_q != '0) begin
        quo_q <= {quo_q[DATA_W-2:0], ge};
        rem_q <= ge ? diff : shifted;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) done_q <= 1'b1;
      end
    end
  end

  assign done      = done_q;
  assign quotient  = quo_q;
  assign remainder = rem_q;

  p_rem_below_divisor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (rem_q < div_q));
endmodule

// File: rtl/rdx_frac_step.sv
module rdx_frac_step #(
  parameter int FRAC_W  = 16,
  parameter int RADIX_W = 5
) (
  input  logic [FRAC_W-1:0]  frac,
  input  logic [RADIX_W-1:0] radix,
  output logic [RADIX_W-1:0] digit,
  output logic [FRAC_W-1:0]  rest
);
  localparam int PROD_W = FRAC_W + RADIX_W;

  logic [PROD_W-1:0] product;

  assign product = {{RADIX_W{1'b0}}, frac} * {{FRAC_W{1'b0}}, radix};
  assign digit   = product[PROD_W-1 -: RADIX_W];
  assign rest    = product[FRAC_W-1:0];
endmodule

// File: rtl/radix_digit_stream.sv
module radix_digit_stream
  import rdx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [RADIX_W-1:0] radix,
  input  logic [LIM_W-1:0]   frac_limit,
  input  logic [INT_W-1:0]   value_int,
  input  logic [FRAC_W-1:0]  value_frac,
  output logic               busy,
  output logic               dig_valid,
  input  logic               dig_ready,
  output logic [DIGIT_W-1:0] dig_value,
  output logic               dig_is_frac,
  output logic               dig_last
);
  rdx_state_e         state_q;
  logic [RADIX_W-1:0] radix_q, radix_eff, fdig_q, step_digit;
  logic [FRAC_W-1:0]  frac_q, step_rest;
  logic [LIM_W-1:0]   lim_q, fcnt_q, fcnt_nx;
  logic               flast_q;
  logic               hs, no_frac, int_last;
  logic               div_load, div_done;
  logic [INT_W-1:0]   div_dividend, div_quo;
  logic [RADIX_W-1:0] div_divisor, div_rem;

  always_comb begin
    if (radix < RADIX_W'(2))       radix_eff = RADIX_W'(2);
    else if (radix > RADIX_W'(16)) radix_eff = RADIX_W'(16);
    else                           radix_eff = radix;
  end

  assign hs           = dig_valid && dig_ready;
  assign no_frac      = (frac_q == '0) || (lim_q == '0);
  assign int_last     = (div_quo == '0) && no_frac;
  assign fcnt_nx      = fcnt_q + 1'b1;
  assign div_load     = ((state_q == ST_IDLE) && start) ||
                        ((state_q == ST_INT_OUT) && hs && (div_quo != '0));
  assign div_dividend = (state_q == ST_IDLE) ? value_int : div_quo;
  assign div_divisor  = (state_q == ST_IDLE) ? radix_eff : radix_q;

  rdx_div_unit #(.DATA_W(INT_W), .DIV_W(RADIX_W)) div_i (
    .clk(clk), .rst_n(rst_n), .load(div_load), .dividend(div_dividend),
    .divisor(div_divisor), .done(div_done), .quotient(div_quo),
    .remainder(div_rem)
  );

  rdx_frac_step #(.FRAC_W(FRAC_W), .RADIX_W(RADIX_W)) mul_i (
    .frac(frac_q), .radix(radix_q), .digit(step_digit), .rest(step_rest)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      radix_q <= RADIX_W'(2);
      frac_q  <= '0;
      lim_q   <= '0;
      fcnt_q  <= '0;
      fdig_q  <= '0;
      flast_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          radix_q <= radix_eff;
          frac_q  <= value_frac;
          lim_q   <= frac_limit;
          fcnt_q  <= '0;
          state_q <= ST_DIV;
        end
        ST_DIV: if (div_done) state_q <= ST_INT_OUT;
        ST_INT_OUT: if (hs) begin
          if (div_quo != '0) state_q <= ST_DIV;
          else if (no_frac)  state_q <= ST_IDLE;
          else               state_q <= ST_MUL;
        end
        ST_MUL: begin
          fdig_q  <= step_digit;
          frac_q  <= step_rest;
          fcnt_q  <= fcnt_nx;
          flast_q <= (step_rest == '0) || (fcnt_nx == lim_q);
          state_q <= ST_FRAC_OUT;
        end
        ST_FRAC_OUT: if (hs) state_q <= flast_q ? ST_IDLE : ST_MUL;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign dig_valid   = (state_q == ST_INT_OUT) || (state_q == ST_FRAC_OUT);
  assign dig_is_frac = (state_q == ST_FRAC_OUT);
  assign dig_value   = (state_q == ST_INT_OUT) ? div_rem[DIGIT_W-1:0]
                                               : fdig_q[DIGIT_W-1:0];
  assign dig_last    = (state_q == ST_INT_OUT) ? int_last
                                               : ((state_q == ST_FRAC_OUT) && flast_q);

  p_int_digit_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_INT_OUT) |-> (div_rem < radix_q));
  p_frac_digit_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FRAC_OUT) |-> (fdig_q < radix_q));
  p_frac_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_valid && dig_is_frac) |-> ((fcnt_q != '0) && (fcnt_q <= lim_q)));
  p_hold_stalled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_valid && !dig_ready) |=> (dig_valid && $stable(dig_value) &&
                                   $stable(dig_is_frac) && $stable(dig_last)));
  p_busy_falls_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && dig_last) |=> !busy);
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(hs && dig_last)) |=> (busy && $stable(radix_q) && $stable(lim_q)));
  p_radix_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((radix_q >= RADIX_W'(2)) && (radix_q <= RADIX_W'(16))));
endmodule

// File: tb/radix_digit_stream_tb_top.sv
module radix_digit_stream_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;

  localparam logic [15:0] T_INT  [NV] = '{16'd53, 16'd0, 16'd0, 16'd2607, 16'd45,
                                           16'd65535, 16'd103, 16'd12345, 16'd1,
                                           16'd999, 16'd65535};
  localparam logic [15:0] T_FRAC [NV] = '{16'h0000, 16'hA000, 16'hB333, 16'h8000,
                                           16'hC000, 16'hFFFF, 16'h6000, 16'h1234,
                                           16'h0000, 16'h4000, 16'h0000};
  localparam logic [4:0]  T_RAD  [NV] = '{5'd2, 5'd2, 5'd2, 5'd16, 5'd7, 5'd10,
                                           5'd8, 5'd3, 5'd0, 5'd31, 5'd16};
  localparam logic [4:0]  T_LIM  [NV] = '{5'd8, 5'd8, 5'd12, 5'd4, 5'd6, 5'd31,
                                           5'd3, 5'd0, 5'd5, 5'd5, 5'd5};
  localparam logic        T_BP   [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1,
                                           1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  radix = 5'd2;
  logic [4:0]  frac_limit = 5'd0;
  logic [15:0] value_int = '0;
  logic [15:0] value_frac = '0;
  logic        dig_ready = 1'b0;
  logic        busy, dig_valid, dig_is_frac, dig_last;
  logic [3:0]  dig_value;

  int checks = 0;
  int fails  = 0;
  int exp_val [64];
  int exp_frc [64];
  int exp_n;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  radix_digit_stream dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .radix(radix),
    .frac_limit(frac_limit), .value_int(value_int), .value_frac(value_frac),
    .busy(busy), .dig_valid(dig_valid), .dig_ready(dig_ready),
    .dig_value(dig_value), .dig_is_frac(dig_is_frac), .dig_last(dig_last)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  // Arithmetic model from R1..R5 and R10
  task automatic build_model(input int iv, input int fv, input int r, input int lim);
    int v, f, p, k;
    exp_n = 0;
    v = iv;
    do begin
      exp_val[exp_n] = v % r; exp_frc[exp_n] = 0; exp_n++;
      v = v / r;
    end while (v != 0);
    f = fv; k = 0;
    while (f != 0 && k < lim) begin
      p = f * r;
      exp_val[exp_n] = p >> 16; exp_frc[exp_n] = 1; exp_n++;
      f = p & 32'hFFFF; k++;
    end
  endtask

  task automatic run_vec(input logic [15:0] iv, input logic [15:0] fv,
                         input logic [4:0] rv, input logic [4:0] lv,
                         input bit bp, input bit poke);
    int eff, idx, wd, held_val, held_last;
    bit fin, stalled;
    eff = (rv < 2) ? 2 : ((rv > 16) ? 16 : int'(rv));  // R10
    build_model(int'(iv), int'(fv), eff, int'(lv));
    @(negedge clk);
    value_int = iv; value_frac = fv; radix = rv; frac_limit = lv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    idx = 0; wd = 0; fin = 0; stalled = 0; held_val = 0; held_last = 0;
    while (!fin && wd < 20000) begin
      if (poke && wd < 6) begin  // R8: disturb operands and request start while busy
        start = 1'b1; value_int = ~iv; value_frac = ~fv; radix = 5'd3; frac_limit = 5'd1;
      end else start = 1'b0;
      dig_ready = bp ? lfsr[0] : 1'b1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      #1;
      if (stalled)  // R9
        check(dig_valid && dig_value == held_val[3:0] && dig_last == held_last[0],
              "R9 hold", int'(dig_value), held_val);
      stalled = dig_valid && !dig_ready;
      held_val = int'(dig_value); held_last = int'(dig_last);
      if (dig_valid && dig_ready) begin
        if (idx >= exp_n) begin
          check(0, "R7 extra digit", idx, exp_n);
          fin = 1;
        end else begin
          check(int'(dig_value) == exp_val[idx], exp_frc[idx] ? "R3 frac digit" : "R1 int digit",
                int'(dig_value), exp_val[idx]);
          check(int'(dig_is_frac) == exp_frc[idx], "R1/R3 frac flag", int'(dig_is_frac), exp_frc[idx]);
          check(int'(dig_value) < eff, "R6 range", int'(dig_value), eff);
          check(dig_last == (idx == exp_n - 1), "R7 last flag", int'(dig_last), int'(idx == exp_n - 1));
          if (dig_last) fin = 1;
          idx++;
        end
      end
      @(negedge clk);
      wd++;
    end
    start = 1'b0;
    dig_ready = 1'b0;
    check(fin, "R7 conversion finished", int'(fin), 1);
    check(idx == exp_n, "R4/R5 digit count", idx, exp_n);
    #1;
    check(!busy, "R7 busy low after last", int'(busy), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 3);
    check(!busy && !dig_valid, "R11 reset state", int'({busy, dig_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !dig_valid, "R11 idle after reset", int'({busy, dig_valid}), 0);

    // Table walk: R1 R2 R3 R4 R5 R6 R7 R9 R10
    for (int i = 0; i < NV; i++)
      run_vec(T_INT[i], T_FRAC[i], T_RAD[i], T_LIM[i], T_BP[i], 1'b0);

    // R8: start pulses with other operands during a conversion are ignored
    run_vec(16'd4660, 16'h2000, 5'd10, 5'd4, 1'b1, 1'b1);

    // R2: zero with zero fraction yields a single zero digit flagged last
    run_vec(16'd0, 16'h0000, 5'd9, 5'd7, 1'b0, 1'b0);

    // R4: non-terminating fraction capped at one digit
    run_vec(16'd7, 16'h5555, 5'd2, 5'd1, 1'b1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule